// File: doc/BRIEF.md
# Fixed-Point Squarer with Rescaling

This block squares a signed 16-bit fixed-point sample that carries 14 fractional bits and hands the result back in the same 16-bit format. The output can therefore be fed straight back into the datapath that produced the input. Internally it forms the exact 32-bit square, which has 28 fractional bits. It then removes the 14 lowest fractional bits, either by dropping them (floor) or by rounding to the nearest code. Any square that does not fit the signed 16-bit output is clamped to the largest positive code.

Samples arrive as a valid/data pair. Each sample carries its own rounding-mode bit. Results leave as a valid/data pair with an overflow flag after a fixed pipeline of three registers: input, product, and rounded/clamped output. A new sample may be accepted on every cycle.

Top module: `fxsq_squarer`

## Requirements
- R1: `vld_o` is high in a given cycle exactly when `vld_i` was high three rising clock edges earlier. Results leave in the order the samples arrived.
- R2: With `rnd_i` = 0 (floor mode), a valid output whose square fits is floor(x*x / 2^14), where x is the two's-complement value of `data_i`.
- R3: With `rnd_i` = 1 (nearest mode), a valid output whose square fits is floor((x*x + 2^13) / 2^14). This equals adding one at product bit 13 before bits 13..0 are dropped.
- R4: When the rescaled value (after rounding) exceeds 32767, `data_o` is 0x7FFF. This includes the input 0x8000 (-2.0), whose square 4.0 is out of range.
- R5: `ovf_o` is high exactly in the cycles where `vld_o` is high and the output was clamped as in R4. It is low in all other cycles.
- R6: The mode bit is captured together with its sample. Changing `rnd_i` on the next cycle has no effect on a sample already in the pipeline.
- R7: While `rst_ni` is low and after its release, before any valid sample has travelled through the pipeline, `vld_o` and `ovf_o` are 0.
- R8: Every valid output has its sign bit (`data_o[15]`) cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Input sample valid |
| rnd_i | input | 1 | Rounding mode for this sample: 0 floor, 1 nearest |
| data_i | input | 16 | Signed input, 14 fractional bits |
| vld_o | output | 1 | Result valid, three cycles after `vld_i` |
| data_o | output | 16 | Squared result, signed, 14 fractional bits |
| ovf_o | output | 1 | Result was clamped to 0x7FFF |

## Verification
The bench builds the block with its default 16-bit width and 14 fractional bits. This keeps the whole input space small enough to sweep every code in both rounding modes, back to back. The sweep reaches the exact boundary where squares start to clamp, the -2.0 corner, and the codes whose discarded bit 13 changes the rounded result. A further segment alternates the mode bit on every cycle and inserts bubbles, which exposes any mode or valid bit that slips relative to its sample.

// File: rtl/fxsq_pkg.sv
package fxsq_pkg;
  typedef enum logic {
    RND_FLOOR = 1'b0,
    RND_NEAR  = 1'b1
  } rnd_mode_e;
endpackage

// File: rtl/fxsq_in_stage.sv
module fxsq_in_stage #(
  parameter int unsigned DATA_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     vld_i,
  input  fxsq_pkg::rnd_mode_e      rnd_i,
  input  logic signed [DATA_W-1:0] data_i,
  output logic                     vld_o,
  output fxsq_pkg::rnd_mode_e      rnd_o,
  output logic signed [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      rnd_o  <= fxsq_pkg::RND_FLOOR;
      data_o <= '0;
    end else begin
      vld_o  <= vld_i;
      rnd_o  <= rnd_i;
      data_o <= data_i;
    end
  end

  // R1
  in_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o == $past(vld_i));
endmodule

// File: rtl/fxsq_mul_stage.sv
module fxsq_mul_stage #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned PROD_W = 2 * DATA_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     vld_i,
  input  fxsq_pkg::rnd_mode_e      rnd_i,
  input  logic signed [DATA_W-1:0] data_i,
  output logic                     vld_o,
  output fxsq_pkg::rnd_mode_e      rnd_o,
  output logic signed [PROD_W-1:0] prod_o
);
  logic signed [PROD_W-1:0] prod_d;

  always_comb prod_d = data_i * data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      rnd_o  <= fxsq_pkg::RND_FLOOR;
      prod_o <= '0;
    end else begin
      vld_o  <= vld_i;
      rnd_o  <= rnd_i;
      prod_o <= prod_d;
    end
  end

  // R1
  mul_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o == $past(vld_i));
  // R8
  prod_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> !prod_o[PROD_W-1]);
  // R6
  mode_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> rnd_o == $past(rnd_i));
endmodule

// File: rtl/fxsq_rnd_sat.sv
module fxsq_rnd_sat #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned FRAC_W = 14,
  localparam int unsigned PROD_W = 2 * DATA_W,
  localparam int unsigned KEEP_W = PROD_W - FRAC_W + 1,
  localparam logic [DATA_W-1:0] MAX_CODE = {1'b0, {(DATA_W-1){1'b1}}}
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     vld_i,
  input  fxsq_pkg::rnd_mode_e      rnd_i,
  input  logic signed [PROD_W-1:0] prod_i,
  output logic                     vld_o,
  output logic        [DATA_W-1:0] data_o,
  output logic                     ovf_o
);
  logic [KEEP_W-1:0] kept;
  logic              half_bit;
  logic              sat;
  logic [DATA_W-1:0] res_d;
  logic              unused_lsb;

  // one extra bit so the rounding carry cannot wrap before the range test
  always_comb begin
    half_bit   = (rnd_i == fxsq_pkg::RND_NEAR) && prod_i[FRAC_W-1];
    kept       = {1'b0, prod_i[PROD_W-1:FRAC_W]} + {{(KEEP_W-1){1'b0}}, half_bit};
    sat        = kept > {{(KEEP_W-DATA_W){1'b0}}, MAX_CODE};
    res_d      = sat ? MAX_CODE : kept[DATA_W-1:0];
    unused_lsb = ^prod_i[FRAC_W-2:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      data_o <= '0;
      ovf_o  <= 1'b0;
    end else begin
      vld_o  <= vld_i;
      data_o <= res_d;
      ovf_o  <= vld_i && sat;
    end
  end

  // R1
  out_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o == $past(vld_i));
  // R4
  sat_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> data_o == MAX_CODE);
  // R5
  ovf_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> vld_o);
  // R8
  non_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> !data_o[DATA_W-1]);
endmodule

// File: rtl/fxsq_squarer.sv
module fxsq_squarer #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned FRAC_W = 14,
  localparam int unsigned PROD_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic              rnd_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ovf_o
);
  logic                     s1_vld;
  fxsq_pkg::rnd_mode_e      s1_rnd;
  logic signed [DATA_W-1:0] s1_data;
  logic                     s2_vld;
  fxsq_pkg::rnd_mode_e      s2_rnd;
  logic signed [PROD_W-1:0] s2_prod;
  fxsq_pkg::rnd_mode_e      rnd_in;

  always_comb rnd_in = fxsq_pkg::rnd_mode_e'(rnd_i);

  fxsq_in_stage #(.DATA_W(DATA_W)) i_in (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (vld_i),
    .rnd_i  (rnd_in),
    .data_i (data_i),
    .vld_o  (s1_vld),
    .rnd_o  (s1_rnd),
    .data_o (s1_data)
  );

  fxsq_mul_stage #(.DATA_W(DATA_W)) i_mul (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (s1_vld),
    .rnd_i  (s1_rnd),
    .data_i (s1_data),
    .vld_o  (s2_vld),
    .rnd_o  (s2_rnd),
    .prod_o (s2_prod)
  );

  fxsq_rnd_sat #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) i_rnd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (s2_vld),
    .rnd_i  (s2_rnd),
    .prod_i (s2_prod),
    .vld_o  (vld_o),
    .data_o (data_o),
    .ovf_o  (ovf_o)
  );
endmodule

// File: tb/test_fxsq_squarer.sv
module test_fxsq_squarer;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        vld_i = 1'b0;
  logic        rnd_i = 1'b0;
  logic [15:0] data_i = '0;
  logic        vld_o;
  logic [15:0] data_o;
  logic        ovf_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;
  logic [2:0] vpipe = '0;

  int    exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  fxsq_squarer i_fxsq_squarer (
    .clk_i(clk), .rst_ni(rst_ni), .vld_i(vld_i), .rnd_i(rnd_i),
    .data_i(data_i), .vld_o(vld_o), .data_o(data_o), .ovf_o(ovf_o)
  );

  // expected {ovf, data} from arithmetic
  function automatic int model(input logic [15:0] x, input logic rnd);
    longint v, q;
    v = longint'($signed(x));
    q = (v * v + (rnd ? 64'sd8192 : 64'sd0)) >>> 14;
    if (q > 32767) return 32'h1_7FFF;
    return int'(q);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [15:0] x, input logic rnd, input string tag);
    @(negedge clk);
    vld_i  = v;
    data_i = x;
    rnd_i  = rnd;
    if (v) begin
      exp_q.push_back(model(x, rnd));
      tag_q.push_back(tag);
    end
  endtask

  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) vpipe <= '0;
    else vpipe <= {vpipe[1:0], vld_i};

  always @(negedge clk) begin
    if (rst_ni) begin
      chk(vld_o == vpipe[2], "R1", int'(vld_o), int'(vpipe[2]));
      if (vld_o && exp_q.size() > 0) begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (t == "")
          t = e[16] ? "R4" : (data_o[0] === 1'bx ? "R2" : "R2/R3");
        chk(data_o == e[15:0], t, int'(data_o), e[15:0]);
        chk(ovf_o == e[16], "R5", int'(ovf_o), e[16]);
        chk(!data_o[15], "R8", int'(data_o[15]), 0);
      end else if (!vld_o) begin
        chk(!ovf_o, "R5", int'(ovf_o), 0);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<190000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!vld_o && !ovf_o, "R7", {30'd0, vld_o, ovf_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!vld_o && !ovf_o, "R7", {30'd0, vld_o, ovf_o}, 0);

    // full sweep, floor mode (R2, R4 at the top of the range and at 0x8000)
    for (int i = 0; i < 65536; i++)
      drive(1'b1, 16'(i), 1'b0, model(16'(i), 1'b0) > 32767 ? "R4" : "R2");
    // full sweep, nearest mode (R3)
    for (int i = 0; i < 65536; i++)
      drive(1'b1, 16'(i), 1'b1, model(16'(i), 1'b1) > 32767 ? "R4" : "R3");
    // R6: alternate mode every cycle with bubbles near the clamp edge
    for (int k = 0; k < 96; k++) begin
      drive(1'b1, 16'(23140 + k), k[0], "R6");
      if (k % 3 == 2) drive(1'b0, 16'hFFFF, ~k[0], "");
    end
    drive(1'b1, 16'h8000, 1'b1, "R4");
    drive(1'b1, 16'h8000, 1'b0, "R4");
    drive(1'b1, 16'h0001, 1'b1, "R3");
    drive(1'b1, 16'h0001, 1'b0, "R2");
    for (int k = 0; k < 6; k++) drive(1'b0, 16'h0, k[0], "");
    chk(exp_q.size() == 0, "R1", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule